// File: doc/BRIEF.md
# Multi-Port Wave Instruction Dispatcher

This block feeds the execution resources of a compute core. It watches several independent in-order instruction streams, called waves, and each cycle sends at most one instruction from each wave to the port that serves that instruction's class. Parallelism comes from serving different waves on different ports in the same cycle. No wave is searched ahead of its head instruction. While one wave's vector operation runs, another wave's scalar or memory operation can go out to its own port.

Each wave presents its head instruction, a three-bit class tag and a ready flag. Each port reports a busy flag. The block answers in the same cycle with one issue strobe per port, which carries the wave number and the instruction, and with one pop strobe per wave. No-op instructions are retired inside the block and never reach a port. The vector ALU port leads to a pool of SIMD units that the block tracks itself. Each SIMD stays occupied for a fixed number of cycles, and vector issue rotates across the pool.

Top module: `wave_dispatcher`

## Requirements
- R1: The class tag selects the port. Tag 1 goes to the scalar ALU/scalar memory port (port 0), tag 2 to branch/message (port 1), tag 3 to vector ALU (port 2), tag 4 to local data share (port 3), tag 5 to export/global share (port 4) and tag 6 to vector memory (port 5). An issue strobe carries the wave number and that wave's head instruction.
- R2: At most five ports issue in one cycle. If all six ports would issue, the vector memory port (port 5) is held back and its wave is not popped.
- R3: A wave whose ready flag is low issues nothing and is not popped. A wave issues or retires at most one instruction per cycle.
- R4: Tags 0 and 7 are no-ops. A ready no-op head is popped in the same cycle, reaches no port, and does not count toward the five-issue limit.
- R5: There are four SIMDs. A SIMD that accepts a vector instruction is occupied for four cycles, counting the issue cycle. A vector issue takes the first free SIMD, searching from a rotating pointer, and the pointer then moves to one past the chosen SIMD. `valu_simd_o` names the SIMD.
- R6: A port whose busy input is high issues nothing. A wave held by a busy port keeps its head and is not popped.
- R7: A wave is popped exactly when its head is issued on a port or retired as a no-op.
- R8: When several ready waves compete for one port, the port grants the first one after the wave it granted last, wrapping from the highest wave number to wave 0.
- R9: While reset is asserted, nothing is issued or popped. After reset, every port gives first priority to wave 0, all SIMDs are free, and SIMD 0 is chosen first.
- R10: While a wave's vector instruction still occupies its SIMD, that wave's next scalar instruction can issue in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| head_instr_i | input | NUM_WAVES*INSTR_W | Head instruction of each wave |
| head_type_i | input | NUM_WAVES*3 | Class tag of each wave's head |
| head_ready_i | input | NUM_WAVES | Head of the wave may issue |
| port_busy_i | input | 6 | Port cannot accept this cycle |
| issue_valid_o | output | 6 | Issue strobe per port |
| issue_wave_o | output | 6*WID | Wave number per port |
| issue_instr_o | output | 6*INSTR_W | Instruction per port |
| valu_simd_o | output | SW | SIMD chosen for the vector issue |
| pop_o | output | NUM_WAVES | Wave head consumed this cycle |

## Verification
The port issue and the no-op retirement can fall in the same cycle. So can the six-way issue and the five-issue cap, and the vector issue and a scalar issue from a wave whose SIMD is still running. A directed cycle places one wave on each of the six ports and two no-op waves at once. The bench expects five strobes, port 5 held back and seven pops. Random phases mix all tags, ready flags and busy flags. A bench model computes the expected outputs each cycle, and every port strobe, wave number, SIMD number and pop is judged against it.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NUM_PORTS = 6;
    localparam int MAX_ISSUE = 5;
    localparam int TYPE_W    = 3;

    typedef enum logic [TYPE_W-1:0] {
        TY_NOP    = 3'd0,
        TY_SALU   = 3'd1,
        TY_BRMSG  = 3'd2,
        TY_VALU   = 3'd3,
        TY_LDS    = 3'd4,
        TY_EXPGDS = 3'd5,
        TY_VMEM   = 3'd6,
        TY_RSVD   = 3'd7
    } itype_e;

    localparam int P_SALU   = 0;
    localparam int P_BRMSG  = 1;
    localparam int P_VALU   = 2;
    localparam int P_LDS    = 3;
    localparam int P_EXPGDS = 4;
    localparam int P_VMEM   = 5;

    // class tag served by a port
    function automatic logic [TYPE_W-1:0] tag_of_port(input int p);
        return TYPE_W'(p + 1);
    endfunction

    function automatic logic is_noop(input logic [TYPE_W-1:0] t);
        return (t == TY_NOP) || (t == TY_RSVD);
    endfunction

endpackage

// File: rtl/disp_rr_pick.sv
module disp_rr_pick #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          gnt_o,
    output logic [IW-1:0] idx_o
);

    // first requester strictly after last_i, wrapping
    always_comb begin
        int cand;
        gnt_o = 1'b0;
        idx_o = '0;
        cand  = 0;
        for (int i = 1; i <= N; i++) begin
            cand = (int'(last_i) + i) % N;
            if (!gnt_o && req_i[cand]) begin
                gnt_o = 1'b1;
                idx_o = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/disp_simd_pool.sv
module disp_simd_pool #(
    parameter  int NUM_SIMD = 4,
    parameter  int OCC      = 4,
    localparam int SW       = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
    localparam int TW       = (OCC > 1) ? $clog2(OCC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    output logic          any_free_o,
    output logic [SW-1:0] sel_o
);

    typedef struct packed {
        logic [NUM_SIMD-1:0][TW-1:0] tmr;
        logic [SW-1:0]               ptr;
    } pool_s;

    pool_s st_d, st_q;

    always_comb begin
        int cand;
        st_d       = st_q;
        any_free_o = 1'b0;
        sel_o      = '0;
        cand       = 0;
        for (int i = 0; i < NUM_SIMD; i++) begin
            cand = (int'(st_q.ptr) + i) % NUM_SIMD;
            if (!any_free_o && (st_q.tmr[cand] == '0)) begin
                any_free_o = 1'b1;
                sel_o      = SW'(cand);
            end
        end
        for (int s = 0; s < NUM_SIMD; s++) begin
            if (st_q.tmr[s] != '0) begin
                st_d.tmr[s] = st_q.tmr[s] - 1'b1;
            end
        end
        if (issue_i && any_free_o) begin
            st_d.tmr[sel_o] = TW'(OCC - 1);
            st_d.ptr        = SW'((int'(sel_o) + 1) % NUM_SIMD);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wave_dispatcher.sv
module wave_dispatcher
    import disp_pkg::*;
#(
    parameter  int NUM_WAVES   = 8,
    parameter  int INSTR_W     = 32,
    parameter  int NUM_SIMD    = 4,
    parameter  int VALU_CYCLES = 4,
    localparam int WID         = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
    localparam int SW          = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_WAVES-1:0][INSTR_W-1:0]       head_instr_i,
    input  logic [NUM_WAVES-1:0][TYPE_W-1:0]        head_type_i,
    input  logic [NUM_WAVES-1:0]                    head_ready_i,
    input  logic [NUM_PORTS-1:0]                    port_busy_i,
    output logic [NUM_PORTS-1:0]                    issue_valid_o,
    output logic [NUM_PORTS-1:0][WID-1:0]           issue_wave_o,
    output logic [NUM_PORTS-1:0][INSTR_W-1:0]       issue_instr_o,
    output logic [SW-1:0]                           valu_simd_o,
    output logic [NUM_WAVES-1:0]                    pop_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0][WID-1:0] last;
    } arb_s;

    arb_s st_d, st_q;

    logic [NUM_PORTS-1:0][NUM_WAVES-1:0] req;
    logic [NUM_PORTS-1:0]                port_ok;
    logic [NUM_PORTS-1:0]                pick_v;
    logic [NUM_PORTS-1:0][WID-1:0]       pick_w;
    logic                                valu_free;
    logic [SW-1:0]                       valu_sel;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        if (p == P_VALU) begin : g_vec
            assign port_ok[p] = rst_n && !port_busy_i[p] && valu_free;
        end else begin : g_other
            assign port_ok[p] = rst_n && !port_busy_i[p];
        end
        for (genvar w = 0; w < NUM_WAVES; w++) begin : g_req
            assign req[p][w] = port_ok[p] && head_ready_i[w]
                               && (head_type_i[w] == tag_of_port(p));
        end
        disp_rr_pick #(.N(NUM_WAVES)) u_pick (
            .req_i  (req[p]),
            .last_i (st_q.last[p]),
            .gnt_o  (pick_v[p]),
            .idx_o  (pick_w[p])
        );
    end

    disp_simd_pool #(.NUM_SIMD(NUM_SIMD), .OCC(VALU_CYCLES)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_valid_o[P_VALU]),
        .any_free_o (valu_free),
        .sel_o      (valu_sel)
    );

    always_comb begin
        int unsigned n_iss;
        st_d          = st_q;
        n_iss         = 0;
        issue_valid_o = '0;
        issue_wave_o  = pick_w;
        issue_instr_o = '0;
        pop_o         = '0;
        valu_simd_o   = valu_sel;
        // ports in index order; the sixth grant is dropped
        for (int p = 0; p < NUM_PORTS; p++) begin
            issue_instr_o[p] = head_instr_i[pick_w[p]];
            if (pick_v[p] && (n_iss < MAX_ISSUE)) begin
                issue_valid_o[p] = 1'b1;
                n_iss            = n_iss + 1;
                st_d.last[p]     = pick_w[p];
                pop_o[pick_w[p]] = 1'b1;
            end
        end
        // no-ops retire here without a port
        for (int w = 0; w < NUM_WAVES; w++) begin
            if (rst_n && head_ready_i[w] && is_noop(head_type_i[w])) begin
                pop_o[w] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                st_q.last[p] <= WID'(NUM_WAVES - 1);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/disp_checker.sv
module disp_checker
    import disp_pkg::*;
#(
    parameter  int NUM_WAVES   = 8,
    parameter  int INSTR_W     = 32,
    parameter  int NUM_SIMD    = 4,
    parameter  int VALU_CYCLES = 4,
    localparam int WID         = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
    localparam int SW          = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_WAVES-1:0][TYPE_W-1:0] head_type_i,
    input logic [NUM_WAVES-1:0]             head_ready_i,
    input logic [NUM_PORTS-1:0]             port_busy_i,
    input logic [NUM_PORTS-1:0]             issue_valid_o,
    input logic [NUM_PORTS-1:0][WID-1:0]    issue_wave_o,
    input logic [SW-1:0]                    valu_simd_o,
    input logic [NUM_WAVES-1:0]             pop_o
);

    // cycles since each SIMD last took a vector issue, saturating
    int since_q [NUM_SIMD];

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SIMD; s++) begin
            if (!rst_n) begin
                since_q[s] <= VALU_CYCLES;
            end else if (issue_valid_o[P_VALU] && (int'(valu_simd_o) == s)) begin
                since_q[s] <= 1;
            end else if (since_q[s] < VALU_CYCLES) begin
                since_q[s] <= since_q[s] + 1;
            end
        end
    end

    a_r2_issue_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_valid_o) <= MAX_ISSUE);

    a_r6_busy_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o & port_busy_i) == '0);

    a_r7_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o & ~head_ready_i) == '0);

    a_r7_issue_pops: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pop_o) >= $countones(issue_valid_o));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_route
        a_r1_route_match: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid_o[p] |->
                (head_ready_i[issue_wave_o[p]]
                 && (head_type_i[issue_wave_o[p]] == TYPE_W'(p + 1))));
    end

    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
        a_r5_simd_occupied: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid_o[P_VALU] && (int'(valu_simd_o) == s))
                |-> (since_q[s] >= VALU_CYCLES));
    end

endmodule

bind wave_dispatcher disp_checker #(
    .NUM_WAVES   (NUM_WAVES),
    .INSTR_W     (INSTR_W),
    .NUM_SIMD    (NUM_SIMD),
    .VALU_CYCLES (VALU_CYCLES)
) u_chk (.*);

// File: tb/wave_dispatcher_bench.sv
module wave_dispatcher_bench;

    localparam int NW  = 8;
    localparam int IW  = 32;
    localparam int NS  = 4;
    localparam int OCC = 4;
    localparam int NP  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW-1:0][IW-1:0] hi;
    logic [NW-1:0][2:0]    ht;
    logic [NW-1:0]         hr;
    logic [NP-1:0]         pb;
    logic [NP-1:0]         iv;
    logic [NP-1:0][2:0]    iw;
    logic [NP-1:0][IW-1:0] ii;
    logic [1:0]            vs;
    logic [NW-1:0]         pp;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    wave_dispatcher u_wave_dispatcher (
        .clk(clk), .rst_n(rst_n), .head_instr_i(hi), .head_type_i(ht),
        .head_ready_i(hr), .port_busy_i(pb), .issue_valid_o(iv),
        .issue_wave_o(iw), .issue_instr_o(ii), .valu_simd_o(vs), .pop_o(pp));

    // bench model state
    int rr_m [NP];
    int tm_m [NS];
    int sp_m;
    logic [NP-1:0] e_v;
    int e_w [NP];
    int e_simd;
    logic [NW-1:0] e_pop;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        int cnt;
        bit anyfree;
        e_v = '0; e_pop = '0; e_simd = 0;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) rr_m[p] = NW - 1;
            for (int s = 0; s < NS; s++) tm_m[s] = 0;
            sp_m = 0;
            return;
        end
        anyfree = 0;
        for (int i = 0; i < NS; i++) begin
            if (!anyfree && tm_m[(sp_m + i) % NS] == 0) begin
                anyfree = 1; e_simd = (sp_m + i) % NS;
            end
        end
        cnt = 0;
        for (int p = 0; p < NP; p++) begin
            bit found;
            int fw;
            found = 0; fw = 0;
            for (int i = 1; i <= NW; i++) begin
                int w;
                w = (rr_m[p] + i) % NW;
                if (!found && hr[w] && int'(ht[w]) == p + 1) begin found = 1; fw = w; end
            end
            if (found && !pb[p] && (p != 2 || anyfree) && cnt < 5) begin
                e_v[p] = 1; e_w[p] = fw; cnt++; e_pop[fw] = 1;
            end
        end
        for (int w = 0; w < NW; w++)
            if (hr[w] && (ht[w] == 3'd0 || ht[w] == 3'd7)) e_pop[w] = 1;
    endtask

    task automatic model_commit();
        for (int p = 0; p < NP; p++) if (e_v[p]) rr_m[p] = e_w[p];
        for (int s = 0; s < NS; s++) if (tm_m[s] > 0) tm_m[s]--;
        if (e_v[2]) begin tm_m[e_simd] = OCC - 1; sp_m = (e_simd + 1) % NS; end
    endtask

    task automatic settle_and_check();
        #1;
        model_eval();
        for (int p = 0; p < NP; p++) begin
            chk("R1 issue strobe", 64'(iv[p]), 64'(e_v[p]));
            if (e_v[p]) begin
                chk("R1 issue wave", 64'(iw[p]), 64'(e_w[p]));
                chk("R1 issue instr", 64'(ii[p]), 64'(hi[e_w[p]]));
            end
        end
        if (e_v[2]) chk("R5 simd choice", 64'(vs), 64'(e_simd));
        chk("R7 pops", 64'(pp), 64'(e_pop));
    endtask

    task automatic advance();
        model_commit();
        @(negedge clk);
    endtask

    task automatic set_all(input logic [2:0] t, input logic r);
        for (int w = 0; w < NW; w++) begin ht[w] = t; hr[w] = r; hi[w] = IW'($urandom); end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        pb = '0;
        set_all(3'd1, 1'b1);
        @(negedge clk);
        // R9: nothing during reset
        for (int c = 0; c < 3; c++) begin
            settle_and_check();
            chk("R9 no issue in reset", 64'(iv), 64'h0);
            chk("R9 no pop in reset", 64'(pp), 64'h0);
            advance();
        end
        rst_n = 1'b1;

        // six classes plus two no-ops in one cycle
        for (int w = 0; w < 6; w++) begin ht[w] = 3'(w + 1); hr[w] = 1'b1; end
        ht[6] = 3'd0; hr[6] = 1'b1;
        ht[7] = 3'd7; hr[7] = 1'b1;
        settle_and_check();
        chk("R2 five strobes, port 5 held", 64'(iv), 64'h1F);
        chk("R4 no-ops popped, port 5 wave kept", 64'(pp), 64'hDF);
        chk("R9 first simd is 0", 64'(vs), 64'h0);
        chk("R9 wave 0 first after reset", 64'(iw[0]), 64'h0);
        advance();

        // R10: scalar from the vector wave next cycle
        set_all(3'd1, 1'b0);
        hr[2] = 1'b1;
        settle_and_check();
        chk("R10 scalar overlaps vector", 64'(iv), 64'h01);
        chk("R10 scalar wave", 64'(iw[0]), 64'h2);
        advance();

        // R5 and R8: vector stream over the pool
        set_all(3'd3, 1'b1);
        for (int k = 0; k < 6; k++) begin
            int exp_s [6] = '{1, 2, 3, 0, 1, 2};
            int exp_w [6] = '{3, 4, 5, 6, 7, 0};
            settle_and_check();
            chk("R5 simd rotation", 64'(vs), 64'(exp_s[k]));
            chk("R8 round robin wrap", 64'(iw[2]), 64'(exp_w[k]));
            advance();
        end

        // R6: busy port holds the wave
        set_all(3'd1, 1'b0);
        hr[1] = 1'b1; pb[0] = 1'b1;
        settle_and_check();
        chk("R6 busy port silent", 64'(iv), 64'h0);
        chk("R6 held wave not popped", 64'(pp), 64'h0);
        advance();
        pb[0] = 1'b0;
        settle_and_check();
        chk("R6 issue after busy clears", 64'(pp), 64'h02);
        advance();

        // R3: not-ready head is skipped
        set_all(3'd6, 1'b0);
        hr[4] = 1'b1;
        settle_and_check();
        chk("R3 ready wave issued", 64'(iw[5]), 64'h4);
        chk("R3 only ready wave popped", 64'(pp), 64'h10);
        advance();

        // constrained random traffic
        set_all(3'd0, 1'b0);
        for (int c = 0; c < 4000; c++) begin
            for (int w = 0; w < NW; w++) hr[w] = ($urandom_range(0, 9) < 7);
            for (int p = 0; p < NP; p++) pb[p] = ($urandom_range(0, 3) == 0);
            settle_and_check();
            advance();
            for (int w = 0; w < NW; w++) begin
                if (e_pop[w]) begin
                    ht[w] = 3'($urandom_range(0, 7));
                    hi[w] = IW'($urandom);
                end
            end
        end

        // reset again mid-run: R9 priority restored
        rst_n = 1'b0;
        settle_and_check();
        advance();
        rst_n = 1'b1;
        pb = '0;
        set_all(3'd4, 1'b1);
        settle_and_check();
        chk("R9 wave 0 first after re-reset", 64'(iw[3]), 64'h0);
        advance();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule